// File: doc/BRIEF.md
# Ordered-Rule Programmable Logic Cell

This block computes a vector of output bits from a vector of argument bits. It uses a short, ordered list of programmable rules. Each rule has three parts:

- a match pattern, in which every argument position is compared against 0 or 1 or is ignored;
- a valid flag;
- one action per output bit.

All valid rules that match the current arguments are applied in index order, so the highest-indexed matching rule decides every output. A typical table opens with an all-ignore default rule at index 0. Later rules then override it for particular cases.

The result is captured in an output register only on a tick from a programmable clock divider. The output therefore moves in step with that tick and not with edges on the inputs. Any low-order output bit can be routed back to replace the argument bit of the same index. Such a bit becomes a state bit: its argument value is the current state and its rule result is the next state. This lets the cell hold a small Moore or Mealy state machine. With no feedback selected, the cell is a registered combinational function.

Rules, the divide value and the feedback selection are loaded through a simple write port. Writes are accepted only while the cell is disabled.

Top module: `rlc_cell`

## Requirements
- R1: After reset, `cell_out` is 0, every rule is invalid, the divide value is 1 and no feedback is selected.
- R2: A valid rule matches when, for every argument position i with `care[i]`=1, argument bit i equals `val[i]`. Positions with `care[i]`=0 are ignored.
- R3: When several valid rules match, the rule with the highest index sets the outputs, overriding lower-indexed rules.
- R4: The action of output j lies at `act[j*A +: A]`, where A = 2 + clog2(N_IN). The low 2 bits are an opcode and the upper bits select an argument index s. Opcode 0 gives 0, 1 gives 1, 2 gives argument s and 3 gives the inverse of argument s.
- R5: On a tick where no valid rule matches, `cell_out` keeps its previous value. Rules written with the valid flag at 0 never match.
- R6: While enabled with divide value D, the output register updates only on every D-th enabled clock edge, counted from the rise of `enable`. A divide value of 0 acts as 1.
- R7: While `enable` is low, `cell_out` holds its value and the divider restarts from zero.
- R8: Rule writes and mode writes presented while `enable` is high are ignored.
- R9: With `cfg_fb[j]` set, argument j is taken from `cell_out[j]` instead of `ext_in[j]`, so the bit behaves as a state bit.
- R10: With `cfg_fb[j]` clear, argument j is `ext_in[j]`, and the cell is a registered function of its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the divider and the output register; blocks configuration writes |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | clog2(N_RULES) | Rule index to write |
| cfg_valid | input | 1 | Valid flag of the written rule |
| cfg_care | input | N_IN | Positions that take part in matching |
| cfg_val | input | N_IN | Required value at the cared positions |
| cfg_act | input | N_OUT*(2+clog2(N_IN)) | Per-output action fields |
| mode_we | input | 1 | Write strobe for divide value and feedback selection |
| cfg_div | input | DIV_W | Clock divide value |
| cfg_fb | input | N_OUT | Feedback selection per low-order argument |
| ext_in | input | N_IN | External argument bits |
| cell_out | output | N_OUT | Registered output bits |

## Verification
The hardest behaviour to reach from the ports is the feedback loop. The next state depends on the registered output, and the external value of a state bit must be shown to have no effect. The bench selects feedback on two bits and drives the external copies of those bits to the opposite value. It then walks a two-bit counter table through a full wrap, one tick at a time. The divider window is reached by enabling at a known negative edge and checking the output after each of the D edges. Locked configuration is checked by writing while running and confirming that both the old table and the old divide rate still apply.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ACT_ZERO = 2'd0,
    ACT_ONE  = 2'd1,
    ACT_COPY = 2'd2,
    ACT_INV  = 2'd3
  } act_op_e;
endpackage

// File: rtl/rlc_rule_store.sv
module rlc_rule_store #(
  parameter int N_IN    = 10,
  parameter int N_RULES = 16,
  parameter int ACT_BITS = 48,
  localparam int AW = $clog2(N_RULES)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [AW-1:0]                      addr,
  input  logic                               valid_i,
  input  logic [N_IN-1:0]                    care_i,
  input  logic [N_IN-1:0]                    val_i,
  input  logic [ACT_BITS-1:0]                act_i,
  output logic [N_RULES-1:0]                 valid_o,
  output logic [N_RULES-1:0][N_IN-1:0]       care_o,
  output logic [N_RULES-1:0][N_IN-1:0]       val_o,
  output logic [N_RULES-1:0][ACT_BITS-1:0]   act_o
);
  // All rules are read every cycle, so storage is kept in flops.
  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[r] <= 1'b0;
      end else if (we && addr == AW'(r)) begin
        valid_o[r] <= valid_i;
      end
    end
    always_ff @(posedge clk) begin
      if (we && addr == AW'(r)) begin
        care_o[r] <= care_i;
        val_o[r]  <= val_i;
        act_o[r]  <= act_i;
      end
    end
  end
endmodule

// File: rtl/rlc_eval.sv
module rlc_eval #(
  parameter int N_IN    = 10,
  parameter int N_OUT   = 8,
  parameter int N_RULES = 16,
  localparam int SEL_W  = $clog2(N_IN),
  localparam int ACT_W  = 2 + SEL_W,
  localparam int ACT_BITS = N_OUT * ACT_W
) (
  input  logic [N_IN-1:0]                   arg,
  input  logic [N_RULES-1:0]                valid,
  input  logic [N_RULES-1:0][N_IN-1:0]      care,
  input  logic [N_RULES-1:0][N_IN-1:0]      val,
  input  logic [N_RULES-1:0][ACT_BITS-1:0]  act,
  output logic [N_OUT-1:0]                  nxt,
  output logic                              hit
);
  import rlc_pkg::*;
  localparam int ARG_X = 1 << SEL_W;

  logic [ARG_X-1:0] arg_x;
  logic [ACT_W-1:0] fld;
  logic [SEL_W-1:0] sel;

  assign arg_x = ARG_X'(arg);

  // Walk rules low to high; each later match overwrites the result.
  always_comb begin
    hit = 1'b0;
    nxt = '0;
    fld = '0;
    sel = '0;
    for (int r = 0; r < N_RULES; r++) begin
      if (valid[r] && (((arg ^ val[r]) & care[r]) == '0)) begin
        hit = 1'b1;
        for (int j = 0; j < N_OUT; j++) begin
          fld = act[r][j*ACT_W +: ACT_W];
          sel = fld[ACT_W-1:2];
          case (act_op_e'(fld[1:0]))
            ACT_ZERO: nxt[j] = 1'b0;
            ACT_ONE:  nxt[j] = 1'b1;
            ACT_COPY: nxt[j] = arg_x[sel];
            ACT_INV:  nxt[j] = ~arg_x[sel];
            default:  nxt[j] = 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rlc_prescaler.sv
module rlc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rlc_cell.sv
module rlc_cell #(
  parameter int N_IN    = 10,
  parameter int N_OUT   = 8,
  parameter int N_RULES = 16,
  parameter int DIV_W   = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                enable,
  input  logic                                cfg_we,
  input  logic [$clog2(N_RULES)-1:0]          cfg_addr,
  input  logic                                cfg_valid,
  input  logic [N_IN-1:0]                     cfg_care,
  input  logic [N_IN-1:0]                     cfg_val,
  input  logic [N_OUT*(2+$clog2(N_IN))-1:0]   cfg_act,
  input  logic                                mode_we,
  input  logic [DIV_W-1:0]                    cfg_div,
  input  logic [N_OUT-1:0]                    cfg_fb,
  input  logic [N_IN-1:0]                     ext_in,
  output logic [N_OUT-1:0]                    cell_out
);
  localparam int ACT_BITS = N_OUT * (2 + $clog2(N_IN));

  logic [DIV_W-1:0]                  div_q;
  logic [N_OUT-1:0]                  fb_q;
  logic [N_IN-1:0]                   arg;
  logic [N_RULES-1:0]                r_valid;
  logic [N_RULES-1:0][N_IN-1:0]      r_care;
  logic [N_RULES-1:0][N_IN-1:0]      r_val;
  logic [N_RULES-1:0][ACT_BITS-1:0]  r_act;
  logic [N_OUT-1:0]                  nxt;
  logic                              hit;
  logic                              tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(1);
      fb_q  <= '0;
    end else if (mode_we && !enable) begin
      div_q <= cfg_div;
      fb_q  <= cfg_fb;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_arg
    if (i < N_OUT) begin : g_fb
      assign arg[i] = fb_q[i] ? cell_out[i] : ext_in[i];
    end else begin : g_ext
      assign arg[i] = ext_in[i];
    end
  end

  rlc_rule_store #(.N_IN(N_IN), .N_RULES(N_RULES), .ACT_BITS(ACT_BITS)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we && !enable), .addr(cfg_addr),
    .valid_i(cfg_valid), .care_i(cfg_care), .val_i(cfg_val), .act_i(cfg_act),
    .valid_o(r_valid), .care_o(r_care), .val_o(r_val), .act_o(r_act)
  );

  rlc_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .N_RULES(N_RULES)) u_eval (
    .arg(arg), .valid(r_valid), .care(r_care), .val(r_val), .act(r_act),
    .nxt(nxt), .hit(hit)
  );

  rlc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(enable), .div(div_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_out <= '0;
    end else if (tick && hit) begin
      cell_out <= nxt;
    end
  end
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int N_OUT = 8,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             mode_we,
  input logic             tick,
  input logic             hit,
  input logic [DIV_W-1:0] div_q,
  input logic [N_OUT-1:0] fb_q,
  input logic [N_OUT-1:0] cell_out
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cell_out == '0 && div_q == DIV_W'(1) && fb_q == '0)); // R1

  AST_NOMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && !hit) |=> $stable(cell_out)); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cell_out)); // R6

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q > DIV_W'(1)) |=> !tick); // R6

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(cell_out)); // R7

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (enable && mode_we) |=> ($stable(div_q) && $stable(fb_q))); // R8
endmodule

bind rlc_cell rlc_checker #(.N_OUT(N_OUT), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .mode_we(mode_we), .tick(tick),
  .hit(hit), .div_q(div_q), .fb_q(fb_q), .cell_out(cell_out)
);

// File: tb/rlc_cell_tb.sv
module rlc_cell_tb;
  localparam int N_IN = 10, N_OUT = 8, N_RULES = 16, DIV_W = 16;
  localparam int AW = 6;
  localparam int AB = N_OUT * AW;

  logic clk = 0, rst = 1, enable = 0, cfg_we = 0, cfg_valid = 0, mode_we = 0;
  logic [3:0]       cfg_addr = '0;
  logic [N_IN-1:0]  cfg_care = '0, cfg_val = '0, ext_in = '0;
  logic [AB-1:0]    cfg_act = '0;
  logic [DIV_W-1:0] cfg_div = 16'd1;
  logic [N_OUT-1:0] cfg_fb = '0, cell_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rlc_cell #(.N_IN(N_IN), .N_OUT(N_OUT), .N_RULES(N_RULES), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_valid(cfg_valid), .cfg_care(cfg_care), .cfg_val(cfg_val), .cfg_act(cfg_act),
    .mode_we(mode_we), .cfg_div(cfg_div), .cfg_fb(cfg_fb), .ext_in(ext_in),
    .cell_out(cell_out)
  );

  function automatic logic [AB-1:0] fset(logic [AB-1:0] a, int j, int op, int sel);
    logic [AB-1:0] r = a;
    r[j*AW +: AW] = AW'((sel << 2) | op);
    return r;
  endfunction

  task automatic check(string tag, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; enable = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr_rule(int idx, logic v, logic [N_IN-1:0] c, logic [N_IN-1:0] m,
                         logic [AB-1:0] a);
    @(negedge clk);
    cfg_addr = 4'(idx); cfg_valid = v; cfg_care = c; cfg_val = m; cfg_act = a; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_mode(int d, logic [N_OUT-1:0] fb);
    @(negedge clk); cfg_div = 16'(d); cfg_fb = fb; mode_we = 1;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic step(logic [N_IN-1:0] v);
    ext_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out after reset", cell_out, 8'h00);
    @(negedge clk); enable = 1; ext_in = '1;
    @(negedge clk); @(negedge clk);
    check("R1 no rule valid after reset", cell_out, 8'h00);
    enable = 0;
  endtask

  task automatic t_and3();
    do_reset();
    wr_rule(0, 1, '0, '0, '0);
    wr_rule(1, 1, 10'h007, 10'h007, fset('0, 0, 1, 0));
    enable = 1;
    for (int v = 0; v < 8; v++) begin
      step(10'(v) | 10'h2A8);
      check("R2 R3 and3", cell_out, (v == 7) ? 8'h01 : 8'h00);
    end
    step(10'h3FF);
    check("R2 don't-care upper bits", cell_out, 8'h01);
    enable = 0;
  endtask

  task automatic t_actions();
    logic [AB-1:0] a;
    do_reset();
    a = fset('0, 1, 2, 5);
    a = fset(a, 2, 3, 5);
    a = fset(a, 3, 1, 0);
    a = fset(a, 7, 2, 9);
    wr_rule(0, 1, '0, '0, a);
    enable = 1;
    step(10'h020); check("R4 copy/inv/const a", cell_out, 8'h0A);
    step(10'h200); check("R4 copy/inv/const b", cell_out, 8'h8C);
    enable = 0;
  endtask

  task automatic t_nomatch();
    do_reset();
    wr_rule(3, 1, 10'h200, 10'h200, fset(fset('0, 0, 1, 0), 4, 1, 0));
    wr_rule(5, 0, '0, '0, {AB/2{2'b01}});
    enable = 1;
    step(10'h200); check("R5 match sets", cell_out, 8'h11);
    step(10'h000); @(negedge clk);
    check("R5 no match holds, invalid ignored", cell_out, 8'h11);
    enable = 0;
  endtask

  task automatic t_prescale();
    do_reset();
    wr_rule(0, 1, '0, '0, fset('0, 0, 2, 0));
    wr_mode(4, '0);
    ext_in = 10'h001;
    enable = 1;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk); check("R6 before 4th edge", cell_out, 8'h00);
    end
    @(negedge clk); check("R6 at 4th edge", cell_out, 8'h01);
    ext_in = 10'h000;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk); check("R6 second window hold", cell_out, 8'h01);
    end
    @(negedge clk); check("R6 second window update", cell_out, 8'h00);
    enable = 0; ext_in = 10'h001;
    for (int e = 0; e < 6; e++) @(negedge clk);
    check("R7 disabled holds", cell_out, 8'h00);
    wr_mode(0, '0);
    enable = 1;
    @(negedge clk); check("R6 divide 0 acts as 1", cell_out, 8'h01);
    enable = 0;
  endtask

  task automatic t_lock();
    do_reset();
    wr_rule(0, 1, '0, '0, fset('0, 0, 2, 0));
    enable = 1;
    ext_in = 10'h000;
    @(negedge clk); cfg_addr = 0; cfg_valid = 1; cfg_care = '0; cfg_val = '0;
    cfg_act = fset('0, 0, 1, 0); cfg_we = 1; cfg_div = 16'd5; mode_we = 1;
    @(negedge clk); cfg_we = 0; mode_we = 0;
    step(10'h000); check("R8 rule write ignored", cell_out, 8'h00);
    step(10'h001); check("R8 mode write ignored", cell_out, 8'h01);
    enable = 0;
  endtask

  task automatic t_fsm();
    logic [AB-1:0] a0, a1;
    do_reset();
    a0 = fset(fset('0, 0, 3, 0), 1, 2, 1);
    a1 = fset(fset('0, 0, 3, 0), 1, 3, 1);
    wr_rule(0, 1, '0, '0, a0);
    wr_rule(1, 1, 10'h001, 10'h001, a1);
    wr_mode(1, 8'h03);
    ext_in = 10'h003;
    enable = 1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R9 state counter", cell_out, 8'(k % 4));
    end
    enable = 0;
    wr_mode(1, 8'h00);
    enable = 1;
    step(10'h002); check("R10 external args a", cell_out, 8'h03);
    step(10'h002); check("R10 no state kept", cell_out, 8'h03);
    step(10'h001); check("R10 external args b", cell_out, 8'h02);
    enable = 0;
  endtask

  initial begin
    t_reset();
    t_and3();
    t_actions();
    t_nomatch();
    t_prescale();
    t_lock();
    t_fsm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule